// File: doc/BRIEF.md
# Burst Byte-Lane Strobe Sequencer

This block turns the address phase of an incrementing write burst into a stream of per-beat byte-lane enables for a data bus of parameterised width. A command carries a start address, a transfer size code (bytes per beat = 2^size) and a length field (beats = length + 1). The block takes it over a valid/ready handshake and then presents one beat at a time: the beat's address, its lane enables and a flag that marks the final beat. Each beat stays on the outputs until the downstream side takes it. The block then moves to the next beat.

The lane enables are computed from the running address, the size and the bus width. This makes narrow transfers and unaligned start addresses come out correctly. The first beat starts at the byte the start address selects and stops at the end of the size-aligned container that holds that byte. Every later beat covers its whole container. A size code wider than the bus is refused: the block raises an error pulse and produces no beats.

Top module: `axi_wstrb_gen`

## Requirements
- R1: After reset, `beat_valid` and `cmd_err` are 0 and `cmd_ready` is 1.
- R2: `cmd_ready` is 0 from the clock edge that accepts a legal command until the final beat is taken. It is 1 in the cycle after that final beat handshake, and `beat_valid` is never 1 while `cmd_ready` is 1.
- R3: A legal command with length field L produces exactly L+1 beats. `beat_last` is 1 on beat L+1 only.
- R4: The address of beat i (counting from 0) is the start address plus i·2^size, modulo 2^ADDR_W.
- R5: The lane enables form a bus of DATA_W/8 bits, where bit k enables byte lane k. For the first beat, with o = address mod (DATA_W/8), bits o through (o OR (2^size−1)) are set and all others are clear.
- R6: For every beat after the first, with o = address mod (DATA_W/8), bits (o AND NOT(2^size−1)) through (o OR (2^size−1)) are set and all others are clear. The beat fills its whole container.
- R7: A command whose 2^size exceeds DATA_W/8 is accepted and sets `cmd_err` to 1 for exactly the following cycle. It produces no beat and leaves `cmd_ready` at 1.
- R8: While `beat_valid` is 1 and `beat_ready` is 0, `beat_valid`, `beat_addr`, `beat_strb` and `beat_last` hold their values into the next cycle.
- R9: Beats appear one cycle after the command handshake. The first beat is valid in the cycle that follows the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_size | input | 3 | Size code, bytes per beat = 2^code |
| cmd_len | input | LEN_W | Beats minus one |
| cmd_err | output | 1 | One-cycle pulse after an oversized command |
| beat_valid | output | 1 | Current beat is presented |
| beat_ready | input | 1 | Downstream takes the current beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_strb | output | DATA_W/8 | Byte-lane enables of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=16 and LEN_W=4. With a four-lane bus, size codes 3 to 7 are all oversized, so random commands hit the refusal path often. Every legal size from single bytes to full width meets every lane offset. The short length field keeps bursts at 16 beats or fewer, so hundreds of commands fit in the run. Address wraparound at 16 bits is reached by random start addresses near the top of the space.

// File: rtl/axi_wstrb_pkg.sv
package axi_wstrb_pkg;

  // Sequencer phase: waiting for a command, or presenting beats of a burst.
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_BURST = 1'b1
  } wsg_phase_e;

  // Width of the transfer size code on the command side.
  localparam int SIZE_W = 3;

endpackage

// File: rtl/wsg_size_dec.sv
// Decodes a size code against the bus width: legality and the in-container
// byte offset mask (2^size - 1) limited to the lane-offset width.
module wsg_size_dec
  import axi_wstrb_pkg::*;
#(
  parameter int STRB_W = 8,
  parameter int OFF_W  = 3
) (
  input  logic [SIZE_W-1:0] size,
  output logic              size_ok,
  output logic [OFF_W-1:0]  off_mask
);

  localparam logic [SIZE_W-1:0] MAX_CODE = SIZE_W'($clog2(STRB_W));

  assign size_ok = (size <= MAX_CODE);

  for (genvar k = 0; k < OFF_W; k++) begin : g_mask
    localparam logic [SIZE_W-1:0] BITPOS = SIZE_W'(k);
    assign off_mask[k] = (size > BITPOS);
  end

endmodule

// File: rtl/wsg_lane_mask.sv
// Per-lane range compare: lane k is enabled when lo <= k <= hi, where
// hi is the top of the size container and lo is either the address offset
// (first beat) or the container base (later beats).
module wsg_lane_mask #(
  parameter int STRB_W = 8,
  parameter int OFF_W  = 3
) (
  input  logic [OFF_W-1:0]  lane_off,
  input  logic [OFF_W-1:0]  off_mask,
  input  logic              first_beat,
  output logic [STRB_W-1:0] strb
);

  logic [OFF_W-1:0] lo_lane;
  logic [OFF_W-1:0] hi_lane;

  always_comb begin
    hi_lane = lane_off | off_mask;
    if (first_beat) begin
      lo_lane = lane_off;
    end else begin
      lo_lane = lane_off & ~off_mask;
    end
  end

  for (genvar k = 0; k < STRB_W; k++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE = OFF_W'(k);
    assign strb[k] = (LANE >= lo_lane) && (LANE <= hi_lane);
  end

endmodule

// File: rtl/wsg_beat_ctrl.sv
// Burst sequencer: loads a command, walks the running address and the
// remaining-beat count, and flags refused commands.
module wsg_beat_ctrl
  import axi_wstrb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic              size_ok,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [OFF_W-1:0]  cmd_mask,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              beat_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [SIZE_W-1:0] cur_size,
  output logic [OFF_W-1:0]  cur_mask,
  output logic              cur_first,
  output logic              cur_last,
  output logic              err_pulse
);

  wsg_phase_e        phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SIZE_W-1:0] size_q;
  logic [OFF_W-1:0]  mask_q;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              first_q, first_d;
  logic              err_q, err_d;

  logic              load_en;
  logic              step_en;
  logic              beat_fire;
  logic              on_last;
  logic [ADDR_W-1:0] step_bytes;

  // ---------------- next-state logic ----------------
  always_comb begin
    on_last    = (left_q == '0);
    beat_fire  = (phase_q == PH_BURST) && beat_ready;
    load_en    = cmd_fire && size_ok && (phase_q == PH_IDLE);
    step_en    = beat_fire && !on_last;
    step_bytes = ADDR_W'(1) << size_q;

    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (load_en) phase_d = PH_BURST;
      PH_BURST: if (beat_fire && on_last) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase

    if (load_en) begin
      addr_d  = cmd_addr;
      left_d  = cmd_len;
      first_d = 1'b1;
    end else begin
      addr_d  = addr_q + step_bytes;
      left_d  = left_q - LEN_W'(1);
      first_d = 1'b0;
    end

    err_d = cmd_fire && !size_ok && (phase_q == PH_IDLE);
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      first_q <= 1'b0;
    end else if (load_en || step_en) begin
      left_q  <= left_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_en || step_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      mask_q <= '0;
    end else if (load_en) begin
      size_q <= cmd_size;
      mask_q <= cmd_mask;
    end
  end

  assign busy      = (phase_q == PH_BURST);
  assign cur_addr  = addr_q;
  assign cur_size  = size_q;
  assign cur_mask  = mask_q;
  assign cur_first = first_q;
  assign cur_last  = on_last;
  assign err_pulse = err_q;

endmodule

// File: rtl/axi_wstrb_gen.sv
// Top: write-burst byte-lane strobe sequencer.
module axi_wstrb_gen
  import axi_wstrb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [2:0]            cmd_size,
  input  logic [LEN_W-1:0]      cmd_len,
  output logic                  cmd_err,
  output logic                  beat_valid,
  input  logic                  beat_ready,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_W/8-1:0]   beat_strb,
  output logic                  beat_last
);

  localparam int STRB_W = DATA_W / 8;
  localparam int OFF_W  = $clog2(STRB_W);

  logic              size_ok;
  logic [OFF_W-1:0]  cmd_mask;
  logic              busy;
  logic              cmd_fire;
  logic [ADDR_W-1:0] cur_addr;
  logic [SIZE_W-1:0] beat_size;
  logic [OFF_W-1:0]  cur_mask;
  logic              cur_first;
  logic              cur_last;
  logic              err_pulse;

  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && !busy;

  wsg_size_dec #(
    .STRB_W (STRB_W),
    .OFF_W  (OFF_W)
  ) u_size_dec (
    .size     (cmd_size),
    .size_ok  (size_ok),
    .off_mask (cmd_mask)
  );

  wsg_beat_ctrl #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .OFF_W  (OFF_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_fire   (cmd_fire),
    .size_ok    (size_ok),
    .cmd_addr   (cmd_addr),
    .cmd_size   (cmd_size),
    .cmd_mask   (cmd_mask),
    .cmd_len    (cmd_len),
    .beat_ready (beat_ready),
    .busy       (busy),
    .cur_addr   (cur_addr),
    .cur_size   (beat_size),
    .cur_mask   (cur_mask),
    .cur_first  (cur_first),
    .cur_last   (cur_last),
    .err_pulse  (err_pulse)
  );

  wsg_lane_mask #(
    .STRB_W (STRB_W),
    .OFF_W  (OFF_W)
  ) u_lanes (
    .lane_off   (cur_addr[OFF_W-1:0]),
    .off_mask   (cur_mask),
    .first_beat (cur_first),
    .strb       (beat_strb)
  );

  assign beat_valid = busy;
  assign beat_addr  = cur_addr;
  assign beat_last  = busy && cur_last;
  assign cmd_err    = err_pulse;

endmodule

// File: rtl/axi_wstrb_gen_chk.sv
// Protocol checker attached to the strobe sequencer.
module axi_wstrb_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_err,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic              beat_last,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [STRB_W-1:0] beat_strb,
  input logic [2:0]        beat_size
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
      && $stable(beat_strb) && $stable(beat_last));

  assert_free_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> cmd_ready && !beat_valid);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !cmd_ready);

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !beat_valid && cmd_ready);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_ready));

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_strb != '0)
      && ($countones(beat_strb) <= (32'd1 << beat_size)));

endmodule

bind axi_wstrb_gen axi_wstrb_gen_chk #(
  .ADDR_W (ADDR_W),
  .STRB_W (DATA_W / 8)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_err    (cmd_err),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_last  (beat_last),
  .beat_addr  (beat_addr),
  .beat_strb  (beat_strb),
  .beat_size  (beat_size)
);

// File: tb/tb_axi_wstrb_gen.sv
module tb_axi_wstrb_gen;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 4;
  localparam int STRB_W = DATA_W / 8;

  logic              clk;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_addr;
  logic [2:0]        cmd_size;
  logic [LEN_W-1:0]  cmd_len;
  logic              cmd_err;
  logic              beat_valid;
  logic              beat_ready;
  logic [ADDR_W-1:0] beat_addr;
  logic [STRB_W-1:0] beat_strb;
  logic              beat_last;

  int checks;
  int errors;

  axi_wstrb_gen #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_size   (cmd_size),
    .cmd_len    (cmd_len),
    .cmd_err    (cmd_err),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_strb  (beat_strb),
    .beat_last  (beat_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected lane enables from the requirement text (R5 first beat, R6 later).
  function automatic logic [STRB_W-1:0] exp_strb(input logic [ADDR_W-1:0] a,
                                                 input int sz, input bit first);
    logic [STRB_W-1:0] s;
    int off, nb, base, lo, hi;
    off  = int'(a) % STRB_W;
    nb   = 1 << sz;
    base = (off / nb) * nb;
    hi   = base + nb - 1;
    lo   = first ? off : base;
    for (int k = 0; k < STRB_W; k++) s[k] = (k >= lo) && (k <= hi);
    return s;
  endfunction

  task automatic run_cmd(input logic [ADDR_W-1:0] a, input int sz, input int len,
                         input bit stalls);
    logic [ADDR_W-1:0] ea;
    @(negedge clk);
    check(cmd_ready === 1'b1, "R2 idle before command", 32'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_addr  = a;
    cmd_size  = 3'(sz);
    cmd_len   = LEN_W'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    if ((1 << sz) > STRB_W) begin
      check(cmd_err === 1'b1, "R7 error pulse", 32'(cmd_err), 1);
      check(beat_valid === 1'b0, "R7 no beat", 32'(beat_valid), 0);
      check(cmd_ready === 1'b1, "R7 stays idle", 32'(cmd_ready), 1);
      @(negedge clk);
      check(cmd_err === 1'b0, "R7 pulse one cycle", 32'(cmd_err), 0);
      check(beat_valid === 1'b0, "R7 still no beat", 32'(beat_valid), 0);
      return;
    end
    check(beat_valid === 1'b1, "R9 first beat next cycle", 32'(beat_valid), 1);
    check(cmd_ready === 1'b0, "R2 busy during burst", 32'(cmd_ready), 0);
    for (int i = 0; i <= len; i++) begin
      ea = ADDR_W'(int'(a) + (i << sz));
      beat_ready = stalls ? (($urandom % 3) != 0) : 1'b1;
      while (!beat_ready) begin
        check(beat_valid === 1'b1, "R3 beat pending", 32'(beat_valid), 1);
        @(negedge clk);
        beat_ready = (($urandom % 3) != 0);
      end
      check(beat_valid === 1'b1, "R3 beat valid", 32'(beat_valid), 1);
      check(beat_addr === ea, "R4 beat address", 32'(beat_addr), 32'(ea));
      check(beat_strb === exp_strb(ea, sz, i == 0), (i == 0) ? "R5 first strobe" : "R6 later strobe",
            32'(beat_strb), 32'(exp_strb(ea, sz, i == 0)));
      check(beat_last === (i == len), "R3 last flag", 32'(beat_last), 32'(i == len));
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check(cmd_ready === 1'b1, "R2 ready after last", 32'(cmd_ready), 1);
    check(beat_valid === 1'b0, "R3 no extra beat", 32'(beat_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sz;
    void'($urandom(32'd1234));
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_addr   = '0;
    cmd_size   = '0;
    cmd_len    = '0;
    beat_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(beat_valid === 1'b0, "R1 reset valid", 32'(beat_valid), 0);
    check(cmd_ready === 1'b1, "R1 reset ready", 32'(cmd_ready), 1);
    check(cmd_err === 1'b0, "R1 reset err", 32'(cmd_err), 0);

    // Directed corners: unaligned word burst, bytes, single aligned beat,
    // halfwords unaligned, refused sizes, wraparound, full length.
    run_cmd(16'h0003, 2, 2, 1'b0);
    run_cmd(16'h0002, 0, 3, 1'b0);
    run_cmd(16'h0010, 2, 0, 1'b0);
    run_cmd(16'h0001, 1, 1, 1'b1);
    run_cmd(16'h0000, 3, 5, 1'b0);
    run_cmd(16'h0005, 7, 0, 1'b0);
    run_cmd(16'hFFFE, 1, 3, 1'b1);
    run_cmd(16'h0007, 2, 15, 1'b1);

    for (int n = 0; n < 300; n++) begin
      sz = (($urandom % 8) == 0) ? 3 + int'($urandom % 5) : int'($urandom % 3);
      run_cmd(ADDR_W'($urandom), sz, int'($urandom % 16), 1'b1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule